// File: doc/BRIEF.md
# Multichannel Serial Command Port

This block is a byte-framed serial slave. A host uses it to program and read back registers for a four-channel device. Three host pins carry the traffic: an active-low select, a data clock and one data line. The data line is split at the block edge into an input, an output and an output-enable, so the pad can build the shared line. The block oversamples all three host pins with the system clock. It samples input bits on rising data-clock edges and moves output bits on falling edges. Every byte has its own select frame.

The first byte of a transaction is a command. Commands come in even/odd pairs: the even code writes a register and the next odd code reads the same register. The command decides how many data bytes follow. A byte counter tracks those bytes, and once the last one has passed, the next frame is taken as a new command.

A channel enable register steers per-channel writes. One write lands in every enabled channel bank at once. A per-channel read is served from the lowest-numbered enabled channel only.

Top module: `chan_cmd_port`

## Requirements
- R1: Each frame carries one byte, shifted most significant bit first in both directions. Input bits are taken on rising edges of `sck_i` while `cs_ni` is low.
- R2: Command 4Ah takes one data byte and stores its bits [3:0] as the channel enable (bit n enables channel n). Command 4Bh returns one byte: 0000b in bits [7:4] and the enable in bits [3:0].
- R3: The even codes 50h..5Eh write per-channel slot s = code bits [3:1]. Slot s takes (s mod 4)+1 data bytes, and data byte k goes to byte k of the slot. Each byte is written into every channel whose enable bit is set, and channels whose bit is clear keep their contents.
- R4: The odd codes 51h..5Fh return the bytes of slot s, in the same order, from the lowest-numbered enabled channel. With no channel enabled they return 00h.
- R5: Commands 46h (write) and 47h (read) access a two-byte global register, independently of the channel enable.
- R6: A code that is not in the command set takes zero data bytes. After the last data byte of any command, the next frame is decoded as a command.
- R7: `sdo_oe_o` is high only during a response frame, while the select is low. It is released within four clocks of `cs_ni` rising. While it is high, `sdo_o` changes only after a falling edge of `sck_i`.
- R8: A frame with a number of rising clock edges other than eight is discarded. It returns the port to waiting for a command and changes no register.
- R9: After reset the channel enable, the global register and all channel slots are zero, and `sdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the host pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Host select, active low, one byte per low period |
| sck_i | input | 1 | Host data clock |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Drive enable for the shared data line |

## Verification
A wrong command phase or byte count shows up on the very next frame. Either the output enable appears during a frame that should be host-driven, or a response frame stays undriven, so a single frame exposes it. A write steered to the wrong bank stays hidden until that bank is read. The bench therefore reads slots back under several enable patterns, including channels that must have kept their old contents. A bad abort path shows up when the frame after a short or long frame is not taken as a command.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_WR = 2'd1, PH_RD = 2'd2} phase_e;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_CHEN = 2'd1, TGT_GLOB = 2'd2, TGT_CHAN = 2'd3} target_e;
  // command pair codes with bit 0 dropped
  localparam logic [6:0] CHEN_PAIR  = 7'h25; // 4Ah / 4Bh
  localparam logic [6:0] GLOB_PAIR  = 7'h23; // 46h / 47h
  localparam logic [3:0] CHAN_GROUP = 4'h5;  // 50h..5Fh
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else last_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = sync_o & ~last_q;
  assign fall_o = ~sync_o & last_q;
endmodule

// File: rtl/ccp_shift.sv
module ccp_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_s_i,
  input  logic       cs_rise_i,
  input  logic       cs_fall_i,
  input  logic       sck_rise_i,
  input  logic       sck_fall_i,
  input  logic       sdi_s_i,
  input  logic       tx_req_i,
  input  logic [7:0] tx_byte_i,
  output logic       frame_done_o,
  output logic       frame_ok_o,
  output logic [7:0] rx_byte_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic [3:0] bit_cnt_q;
  logic [7:0] rx_q, tx_q;
  logic       oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        bit_cnt_q <= '0;
        if (tx_req_i) begin
          tx_q <= tx_byte_i;
          oe_q <= 1'b1;
        end
      end else if (!cs_s_i && sck_rise_i) begin
        rx_q <= {rx_q[6:0], sdi_s_i};
        if (bit_cnt_q != 4'd9) bit_cnt_q <= bit_cnt_q + 4'd1; // saturate: 9 means too long
      end else if (!cs_s_i && sck_fall_i && oe_q) begin
        tx_q <= {tx_q[6:0], 1'b0};
      end
      if (cs_rise_i) oe_q <= 1'b0;
    end
  end

  assign frame_done_o = cs_rise_i;
  assign frame_ok_o   = (bit_cnt_q == 4'd8);
  assign rx_byte_o    = rx_q;
  assign sdo_o        = oe_q & tx_q[7];
  assign sdo_oe_o     = oe_q;
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned MAX_LEN = 4,
  parameter int unsigned GLOB_BYTES = 2,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_done_i,
  input  logic             frame_ok_i,
  input  logic [7:0]       rx_byte_i,
  output phase_e           phase_o,
  output logic [LEN_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output target_e          tgt_o,
  output logic [2:0]       slot_o,
  output logic             wr_en_o
);
  typedef struct packed {
    target_e          tgt;
    logic [LEN_W-1:0] len;
  } dec_t;

  function automatic dec_t decode(input logic [7:0] c);
    dec_t d;
    d.tgt = TGT_NONE;
    d.len = '0;
    if (c[7:1] == CHEN_PAIR) begin
      d.tgt = TGT_CHEN;
      d.len = LEN_W'(1);
    end else if (c[7:1] == GLOB_PAIR) begin
      d.tgt = TGT_GLOB;
      d.len = LEN_W'(GLOB_BYTES);
    end else if (c[7:4] == CHAN_GROUP && 32'(c[3:1]) < N_SLOTS) begin
      d.tgt = TGT_CHAN;
      d.len = LEN_W'((32'(c[3:1]) % MAX_LEN) + 1);
    end
    return d;
  endfunction

  phase_e           phase_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] idx_q;
  dec_t             dec_cur, dec_in;
  logic             last_byte;

  assign dec_cur   = decode(cmd_q);
  assign dec_in    = decode(rx_byte_i);
  assign last_byte = ((idx_q + LEN_W'(1)) == dec_cur.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cmd_q   <= '0;
      idx_q   <= '0;
    end else if (frame_done_i) begin
      if (!frame_ok_i) begin
        phase_q <= PH_CMD;
      end else begin
        unique case (phase_q)
          PH_CMD: begin
            cmd_q <= rx_byte_i;
            idx_q <= '0;
            if (dec_in.tgt != TGT_NONE) phase_q <= rx_byte_i[0] ? PH_RD : PH_WR;
          end
          PH_WR, PH_RD: begin
            if (last_byte) phase_q <= PH_CMD;
            else idx_q <= idx_q + LEN_W'(1);
          end
          default: phase_q <= PH_CMD;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign len_o   = dec_cur.len;
  assign tgt_o   = dec_cur.tgt;
  assign slot_o  = cmd_q[3:1];
  assign wr_en_o = frame_done_i && frame_ok_i && (phase_q == PH_WR);
endmodule

// File: rtl/ccp_regs.sv
module ccp_regs
  import ccp_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned MAX_LEN = 4,
  parameter int unsigned GLOB_BYTES = 2,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int unsigned BYTE_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int unsigned GIDX_W = (GLOB_BYTES > 1) ? $clog2(GLOB_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  target_e           tgt_i,
  input  logic [2:0]        slot_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_byte_o,
  output logic [NUM_CH-1:0] chen_o,
  output logic [NUM_CH-1:0] rd_sel_o
);
  logic [NUM_CH-1:0] chen_q;
  logic [7:0]        glob_q [GLOB_BYTES];
  logic [7:0]        ch_rd  [NUM_CH];
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] bidx;
  logic [GIDX_W-1:0] gidx;
  logic [7:0]        chan_byte;
  logic              unused_idx;

  assign slot       = slot_i[SLOT_W-1:0];
  assign bidx       = idx_i[BYTE_W-1:0];
  assign gidx       = idx_i[GIDX_W-1:0];
  assign unused_idx = ^{idx_i, slot_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chen_q <= '0;
      for (int g = 0; g < GLOB_BYTES; g++) glob_q[g] <= '0;
    end else if (wr_en_i) begin
      if (tgt_i == TGT_CHEN) chen_q <= wr_data_i[NUM_CH-1:0];
      if (tgt_i == TGT_GLOB) glob_q[gidx] <= wr_data_i;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    logic [7:0] mem_q [N_SLOTS][MAX_LEN];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < N_SLOTS; s++)
          for (int b = 0; b < MAX_LEN; b++) mem_q[s][b] <= '0;
      end else if (wr_en_i && tgt_i == TGT_CHAN && chen_q[ch]) begin
        mem_q[slot][bidx] <= wr_data_i; // broadcast to every enabled bank
      end
    end
    assign ch_rd[ch] = mem_q[slot][bidx];
  end

  // isolate lowest set enable bit
  assign rd_sel_o = chen_q & (~chen_q + NUM_CH'(1));

  always_comb begin
    chan_byte = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (rd_sel_o[ch]) chan_byte = chan_byte | ch_rd[ch];
  end

  always_comb begin
    unique case (tgt_i)
      TGT_CHEN: rd_byte_o = 8'(chen_q);
      TGT_GLOB: rd_byte_o = glob_q[gidx];
      TGT_CHAN: rd_byte_o = chan_byte;
      default:  rd_byte_o = '0;
    endcase
  end

  assign chen_o = chen_q;
endmodule

// File: rtl/chan_cmd_port.sv
module chan_cmd_port
  import ccp_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned MAX_LEN = 4,
  parameter int unsigned GLOB_BYTES = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_MAX = (MAX_LEN > GLOB_BYTES) ? MAX_LEN : GLOB_BYTES,
  localparam int unsigned LEN_W = $clog2(LEN_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [2:0]        pin_s, pin_rise, pin_fall;
  logic              cs_s, cs_rise, cs_fall, sck_rise, sck_fall, sdi_s;
  logic              unused_edges;
  logic              frame_done, frame_ok, wr_en, tx_req;
  logic [7:0]        rx_byte, rd_byte;
  phase_e            phase;
  target_e           tgt;
  logic [2:0]        slot;
  logic [LEN_W-1:0]  idx, len;
  logic [NUM_CH-1:0] chen, rd_sel;

  ccp_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_ni, sck_i, sdi_i}),
    .sync_o (pin_s),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_s         = pin_s[2];
  assign cs_rise      = pin_rise[2];
  assign cs_fall      = pin_fall[2];
  assign sck_rise     = pin_rise[1];
  assign sck_fall     = pin_fall[1];
  assign sdi_s        = pin_s[0];
  assign unused_edges = pin_rise[0] ^ pin_fall[0] ^ pin_s[1];
  assign tx_req       = (phase == PH_RD);

  ccp_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (cs_s),
    .cs_rise_i   (cs_rise),
    .cs_fall_i   (cs_fall),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .sdi_s_i     (sdi_s),
    .tx_req_i    (tx_req),
    .tx_byte_i   (rd_byte),
    .frame_done_o(frame_done),
    .frame_ok_o  (frame_ok),
    .rx_byte_o   (rx_byte),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  ccp_ctrl #(
    .N_SLOTS   (N_SLOTS),
    .MAX_LEN   (MAX_LEN),
    .GLOB_BYTES(GLOB_BYTES),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(frame_done),
    .frame_ok_i  (frame_ok),
    .rx_byte_i   (rx_byte),
    .phase_o     (phase),
    .idx_o       (idx),
    .len_o       (len),
    .tgt_o       (tgt),
    .slot_o      (slot),
    .wr_en_o     (wr_en)
  );

  ccp_regs #(
    .NUM_CH    (NUM_CH),
    .N_SLOTS   (N_SLOTS),
    .MAX_LEN   (MAX_LEN),
    .GLOB_BYTES(GLOB_BYTES),
    .IDX_W     (LEN_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .tgt_i    (tgt),
    .slot_i   (slot),
    .idx_i    (idx),
    .wr_data_i(rx_byte),
    .rd_byte_o(rd_byte),
    .chen_o   (chen),
    .rd_sel_o (rd_sel)
  );
endmodule

// File: rtl/chan_cmd_port_chk.sv
module chan_cmd_port_chk
  import ccp_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned LEN_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              sck_fall,
  input logic              frame_done,
  input logic              frame_ok,
  input phase_e            phase,
  input logic [LEN_W-1:0]  idx,
  input logic [LEN_W-1:0]  len,
  input logic              wr_en,
  input logic [NUM_CH-1:0] chen,
  input logic [NUM_CH-1:0] rd_sel,
  input logic              sdo_o,
  input logic              sdo_oe_o
);
  assert_oe_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_oe_o);

  assert_oe_read_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> phase == PH_RD);

  assert_dout_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && !sck_fall && !cs_s) |=> $stable(sdo_o));

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !frame_ok) |=> phase == PH_CMD);

  assert_chen_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(chen));

  assert_idx_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_CMD) |-> idx < len);

  assert_rd_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel) && ((chen != '0) == (rd_sel != '0)));
endmodule

bind chan_cmd_port chan_cmd_port_chk #(
  .NUM_CH(NUM_CH),
  .LEN_W (LEN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .sck_fall  (sck_fall),
  .frame_done(frame_done),
  .frame_ok  (frame_ok),
  .phase     (phase),
  .idx       (idx),
  .len       (len),
  .wr_en     (wr_en),
  .chen      (chen),
  .rd_sel    (rd_sel),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/chan_cmd_port_tb.sv
`timescale 1ns/1ps
module chan_cmd_port_tb;
  localparam int HALF = 8;
  localparam int OFF  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sck_i = 1'b0;
  logic sdi_i = 1'b0;
  logic sdo_o, sdo_oe_o;

  always #5 clk = ~clk;

  chan_cmd_port u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] v;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  // bench model of register contents
  logic [3:0] m_en;
  logic [7:0] m_glob [2];
  logic [7:0] m_bank [4][8][4];

  bit         oe_seen;
  logic [7:0] got;
  int         nbit;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: rebuild response bytes and pop the scoreboard
  always @(negedge cs_ni) nbit = 0;
  always @(posedge sck_i) begin
    if (!cs_ni && sdo_oe_o) begin
      oe_seen = 1'b1;
      got = {got[6:0], sdo_o};
      nbit++;
      if (nbit == 8) begin
        nbit = 0;
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected response byte", int'(got), 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(got == e.v, e.req, "response byte", int'(got), int'(e.v));
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] b, input int nbits);
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi_i = b[7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_ni = 1'b1;
    repeat (OFF) @(negedge clk);
  endtask

  function automatic int cmd_len(input logic [7:0] c);
    if (c[7:1] == 7'h25) return 1;
    if (c[7:1] == 7'h23) return 2;
    if (c[7:4] == 4'h5) return (int'(c[3:1]) % 4) + 1;
    return 0;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] c, input int k);
    if (c[7:1] == 7'h25) return {4'b0000, m_en};
    if (c[7:1] == 7'h23) return m_glob[k];
    if (c[7:4] == 4'h5) begin
      for (int ch = 0; ch < 4; ch++)
        if (m_en[ch]) return m_bank[ch][c[3:1]][k];
      return 8'h00;
    end
    return 8'h00;
  endfunction

  task automatic model_write(input logic [7:0] c, input int k, input logic [7:0] d);
    if (c[7:1] == 7'h25) m_en = d[3:0];
    else if (c[7:1] == 7'h23) m_glob[k] = d;
    else if (c[7:4] == 4'h5)
      for (int ch = 0; ch < 4; ch++)
        if (m_en[ch]) m_bank[ch][c[3:1]][k] = d;
  endtask

  task automatic quiet_frame(input logic [7:0] b, input int nbits, input string req);
    oe_seen = 1'b0;
    xfer(b, nbits);
    chk(!oe_seen, "R7", {req, " line driven in host frame"}, int'(oe_seen), 0);
  endtask

  task automatic wr_seq(input logic [7:0] c, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input logic [7:0] d3, input string req);
    logic [7:0] d [4];
    d = '{d0, d1, d2, d3};
    quiet_frame(c, 8, req);
    for (int k = 0; k < cmd_len(c); k++) begin
      quiet_frame(d[k], 8, req);
      model_write(c, k, d[k]);
    end
  endtask

  task automatic rd_seq(input logic [7:0] c, input string req);
    quiet_frame(c, 8, req);
    for (int k = 0; k < cmd_len(c); k++) begin
      exp_t e;
      e.v = model_read(c, k);
      e.req = req;
      exp_q.push_back(e);
      oe_seen = 1'b0;
      xfer(8'hFF, 8);
      chk(oe_seen, "R7", {req, " response frame not driven"}, int'(oe_seen), 1);
      chk(exp_q.size() == 0, req, "response byte missing", exp_q.size(), 0);
    end
    chk(sdo_oe_o == 1'b0, "R7", "line released after response", int'(sdo_oe_o), 0);
  endtask

  initial begin
    m_en = '0;
    m_glob = '{8'h00, 8'h00};
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        for (int b = 0; b < 4; b++) m_bank[c][s][b] = 8'h00;

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    chk(sdo_oe_o == 1'b0, "R9", "oe after reset", int'(sdo_oe_o), 0);
    rd_seq(8'h4B, "R9");
    rd_seq(8'h47, "R9");
    rd_seq(8'h57, "R4");          // no channel enabled: zeros

    // R2: channel enable write / read
    wr_seq(8'h4A, 8'hF1, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h4B, "R2");

    // R3: one-byte slot into channel 0
    wr_seq(8'h50, 8'hA5, 8'h00, 8'h00, 8'h00, "R3");
    rd_seq(8'h51, "R3");

    // R3: broadcast 4-byte slot 3 into channels 1 and 2
    wr_seq(8'h4A, 8'h06, 8'h00, 8'h00, 8'h00, "R2");
    wr_seq(8'h56, 8'h12, 8'h34, 8'h56, 8'h78, "R3");
    wr_seq(8'h4A, 8'h02, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R3");
    wr_seq(8'h4A, 8'h04, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R3");
    wr_seq(8'h4A, 8'h01, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R3");           // channel 0 untouched
    wr_seq(8'h4A, 8'h08, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R3");           // channel 3 untouched

    // R4: lowest enabled channel wins
    wr_seq(8'h4A, 8'h04, 8'h00, 8'h00, 8'h00, "R2");
    wr_seq(8'h56, 8'hC3, 8'h3C, 8'h99, 8'h66, "R3");
    wr_seq(8'h4A, 8'h06, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R4");
    wr_seq(8'h4A, 8'h0C, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h57, "R4");
    wr_seq(8'h4A, 8'h0F, 8'h00, 8'h00, 8'h00, "R2");
    wr_seq(8'h5A, 8'h5A, 8'hE7, 8'h00, 8'h00, "R3");  // slot 5, two bytes
    wr_seq(8'h4A, 8'h08, 8'h00, 8'h00, 8'h00, "R2");
    rd_seq(8'h5B, "R4");

    // R5 / R1: global register, bit order patterns
    wr_seq(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, "R2");
    wr_seq(8'h46, 8'h01, 8'h80, 8'h00, 8'h00, "R5");
    rd_seq(8'h47, "R1");
    rd_seq(8'h47, "R5");

    // R6: undefined codes take no data bytes
    quiet_frame(8'h30, 8, "R6");
    quiet_frame(8'h00, 8, "R6");
    rd_seq(8'h4B, "R6");

    // R8: short data frame discarded, next frame is a command
    wr_seq(8'h4A, 8'h01, 8'h00, 8'h00, 8'h00, "R2");
    quiet_frame(8'h50, 8, "R8");
    quiet_frame(8'h3C, 5, "R8");
    rd_seq(8'h51, "R8");           // still A5

    // R8: long frame discarded, enable unchanged
    quiet_frame(8'h4A, 8, "R8");
    quiet_frame(8'h0E, 9, "R8");
    rd_seq(8'h4B, "R8");

    // R8: short command frame, then a normal read
    quiet_frame(8'h47, 3, "R8");
    rd_seq(8'h47, "R8");

    // R6: after last byte of a 4-byte write, next frame is a command
    wr_seq(8'h56, 8'hDE, 8'hAD, 8'hBE, 8'hEF, "R6");
    rd_seq(8'h57, "R6");

    chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule